// File: doc/BRIEF.md
# Transceiver Recalibration Request Sequencer

This block works out which calibration engines of a multi-channel serial transceiver must run again after a clocking or data-rate change. It then starts them one at a time. An event pulse samples a set of change flags. The flags cover LC-tank PLLs given a new VCO frequency, fractional PLLs whose rate moved either through the VCO or only through the post-divider, channels whose clock-recovery PLL serves as the transmit clock, channels given a new rate configuration, and, on a power-up event, cascade and bonding roles and a bad reference clock. The block turns these flags into a vector of pending calibration requests.

Pending requests are served one at a time in a fixed priority order. Each start is a one-cycle strobe on a single bit. The block waits for the matching done pulse, or for a programmable timeout, before it picks the next request. LC-PLL requests are held back while any transmitter that is active, not in reset and not clocked by a fractional PLL could be disturbed. While they wait, other eligible requests go ahead.

Top module: `xcvr_recal_seq`

## Requirements
- R1: During and right after reset, `cal_start` is all zero and `busy`, `all_done` and `tmo_err` are low.
- R2: A rate event (`evt_valid`=1, `evt_powerup`=0) requests LC PLL i exactly when `lc_vco_new[i]` is 1.
- R3: A rate event requests fractional PLL j when `frac_vco_new[j]` is 1 and `frac_div_only[j]` is 0. When the change was made only through the post-divider, no request is made.
- R4: A rate event with `ch_cdr_txclk[k]` or `ch_rate_new[k]` set requests both the receive and the transmit calibration of channel k, and every receive calibration is started before any transmit calibration that is pending at the same time.
- R5: A power-up event (`evt_powerup`=1) requests every PLL flagged in `lc_bond`, `frac_bond` or `frac_cascade`. If `refclk_bad` is 1, it requests every PLL and every channel.
- R6: An LC PLL start is issued only when every channel k satisfies `tx_active[k]`=0, or `tx_src_frac[k]`=1, or `tx_in_reset[k]`=1. Otherwise the request stays pending while other eligible requests are served.
- R7: `cal_start` is one-hot or zero, and each strobe lasts one cycle. The first start appears one cycle after the event is captured. No further start is issued until the running engine's `cal_done` bit pulses or a timeout occurs. `cal_done` bits of engines that are not running are ignored.
- R8: Request bit layout is LC PLLs at [NLC-1:0], then fractional PLLs, then receive channels, then transmit channels. Among eligible pending requests the lowest bit starts first.
- R9: `busy` is high while a calibration runs or any request is pending. `all_done` pulses for one cycle in the cycle where `busy` first drops.
- R10: If the running engine's done pulse has not arrived by the `tmo_limit`-th clock edge after the start strobe (`tmo_limit` ≥ 1), `tmo_err` pulses for one cycle after that edge. The request is dropped and the next one may start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Samples the change flags into the pending set |
| evt_powerup | input | 1 | 1: power-up event, 0: rate-change event |
| refclk_bad | input | 1 | Reference clock was absent or changed frequency (power-up) |
| lc_vco_new | input | NLC | LC PLL given a new VCO frequency |
| frac_vco_new | input | NFR | Fractional PLL rate changed |
| frac_div_only | input | NFR | That change was made only through the post-divider |
| lc_bond | input | NLC | LC PLL drives feedback-compensation bonding |
| frac_bond | input | NFR | Fractional PLL drives feedback-compensation bonding |
| frac_cascade | input | NFR | Fractional PLL fed by an upstream PLL |
| ch_cdr_txclk | input | NCH | Channel clock-recovery PLL used as transmit clock |
| ch_rate_new | input | NCH | Channel reconfigured for a new data rate |
| tx_active | input | NCH | Transmitter sending |
| tx_src_frac | input | NCH | Transmitter clocked by a fractional PLL |
| tx_in_reset | input | NCH | Transmitter held in reset |
| cal_done | input | NREQ | Done pulse per calibration engine |
| tmo_limit | input | TMO_W | Timeout in cycles |
| cal_start | output | NREQ | One-cycle start strobe per calibration engine |
| busy | output | 1 | Work pending or running |
| all_done | output | 1 | Queue has just emptied |
| tmo_err | output | 1 | Running calibration timed out |

## Verification
The pending set is updated on the edge that samples `evt_valid`. A start strobe is due on the next edge, provided the sequencer is idle and the request is eligible. After the edge that samples the matching done bit, the next start can follow one edge later. `tmo_err` appears after the `tmo_limit`-th edge following the start. `busy` and `all_done` change on the same edge as the state that drives them. The bench drives and samples on the falling edge. Each sample is compared with a bench model that replays these per-edge rules from the inputs held before that edge. Directed sequences then check the logged start order and the exact timeout distance.

// File: rtl/recal_pkg.sv
package recal_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // Channel-level transmit status used by the LC-PLL gate
    function automatic logic tx_quiet(input logic active, input logic src_frac,
                                      input logic in_reset);
        return !active || src_frac || in_reset;
    endfunction

endpackage

// File: rtl/recal_req_map.sv
module recal_req_map #(
    parameter int NLC  = 2,
    parameter int NFR  = 2,
    parameter int NCH  = 4,
    localparam int NREQ = NLC + NFR + 2 * NCH
) (
    input  logic             evt_powerup,
    input  logic             refclk_bad,
    input  logic [NLC-1:0]   lc_vco_new,
    input  logic [NFR-1:0]   frac_vco_new,
    input  logic [NFR-1:0]   frac_div_only,
    input  logic [NLC-1:0]   lc_bond,
    input  logic [NFR-1:0]   frac_bond,
    input  logic [NFR-1:0]   frac_cascade,
    input  logic [NCH-1:0]   ch_cdr_txclk,
    input  logic [NCH-1:0]   ch_rate_new,
    output logic [NREQ-1:0]  req_mask
);
    logic [NLC-1:0] lc_m;
    logic [NFR-1:0] fr_m;
    logic [NCH-1:0] ch_m;

    always_comb begin
        if (evt_powerup) begin
            lc_m = lc_bond | {NLC{refclk_bad}};
            fr_m = frac_bond | frac_cascade | {NFR{refclk_bad}};
            ch_m = {NCH{refclk_bad}};
        end else begin
            lc_m = lc_vco_new;
            fr_m = frac_vco_new & ~frac_div_only;
            ch_m = ch_cdr_txclk | ch_rate_new;
        end
    end

    // layout: TX channels | RX channels | fractional PLLs | LC PLLs
    assign req_mask = {ch_m, ch_m, fr_m, lc_m};

endmodule

// File: rtl/recal_pick.sv
module recal_pick #(
    parameter int N = 12
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic [N:0] taken;

    assign taken[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]   = req[i] & ~taken[i];
        assign taken[i+1] = taken[i] | req[i];
    end

endmodule

// File: rtl/recal_timer.sv
module recal_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic             done,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);
    logic [TMO_W-1:0] cnt_q;
    logic [TMO_W-1:0] cnt_inc;

    assign cnt_inc = cnt_q + TMO_W'(1);
    assign expire  = run && !done && (cnt_inc == limit);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_inc;
        end
    end

endmodule

// File: rtl/xcvr_recal_seq.sv
module xcvr_recal_seq
    import recal_pkg::*;
#(
    parameter int NLC   = 2,
    parameter int NFR   = 2,
    parameter int NCH   = 4,
    parameter int TMO_W = 8,
    localparam int NREQ = NLC + NFR + 2 * NCH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_valid,
    input  logic             evt_powerup,
    input  logic             refclk_bad,
    input  logic [NLC-1:0]   lc_vco_new,
    input  logic [NFR-1:0]   frac_vco_new,
    input  logic [NFR-1:0]   frac_div_only,
    input  logic [NLC-1:0]   lc_bond,
    input  logic [NFR-1:0]   frac_bond,
    input  logic [NFR-1:0]   frac_cascade,
    input  logic [NCH-1:0]   ch_cdr_txclk,
    input  logic [NCH-1:0]   ch_rate_new,
    input  logic [NCH-1:0]   tx_active,
    input  logic [NCH-1:0]   tx_src_frac,
    input  logic [NCH-1:0]   tx_in_reset,
    input  logic [NREQ-1:0]  cal_done,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic [NREQ-1:0]  cal_start,
    output logic             busy,
    output logic             all_done,
    output logic             tmo_err
);
    localparam logic [NREQ-1:0] LC_MASK = NREQ'((1 << NLC) - 1);

    seq_state_e      state_q;
    logic [NREQ-1:0] pend_q;
    logic [NREQ-1:0] cur_q;
    logic [NREQ-1:0] start_q;
    logic            tmo_q;
    logic            busy_q;

    logic [NREQ-1:0] new_req;
    logic [NREQ-1:0] elig;
    logic [NREQ-1:0] grant;
    logic [NCH-1:0]  ch_quiet;
    logic            lc_ok;
    logic            launch;
    logic            fin;
    logic            expire;

    recal_req_map #(.NLC(NLC), .NFR(NFR), .NCH(NCH)) u_map (
        .evt_powerup  (evt_powerup),
        .refclk_bad   (refclk_bad),
        .lc_vco_new   (lc_vco_new),
        .frac_vco_new (frac_vco_new),
        .frac_div_only(frac_div_only),
        .lc_bond      (lc_bond),
        .frac_bond    (frac_bond),
        .frac_cascade (frac_cascade),
        .ch_cdr_txclk (ch_cdr_txclk),
        .ch_rate_new  (ch_rate_new),
        .req_mask     (new_req)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_quiet
        assign ch_quiet[k] = tx_quiet(tx_active[k], tx_src_frac[k], tx_in_reset[k]);
    end

    assign lc_ok = &ch_quiet;
    assign elig  = pend_q & (lc_ok ? '1 : ~LC_MASK);

    recal_pick #(.N(NREQ)) u_pick (
        .req  (elig),
        .grant(grant)
    );

    assign launch = (state_q == ST_IDLE) && (|grant);
    assign fin    = (state_q == ST_RUN) && (|(cal_done & cur_q));

    recal_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .load  (launch),
        .run   (state_q == ST_RUN),
        .done  (fin),
        .limit (tmo_limit),
        .expire(expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            cur_q   <= '0;
            start_q <= '0;
            tmo_q   <= 1'b0;
            busy_q  <= 1'b0;
        end else begin
            start_q <= '0;
            tmo_q   <= 1'b0;
            busy_q  <= busy;
            pend_q  <= (pend_q & ~(launch ? grant : '0))
                       | (evt_valid ? new_req : '0);
            if (launch) begin
                start_q <= grant;
                cur_q   <= grant;
                state_q <= ST_RUN;
            end else if (fin) begin
                cur_q   <= '0;
                state_q <= ST_IDLE;
            end else if (expire) begin
                cur_q   <= '0;
                tmo_q   <= 1'b1;
                state_q <= ST_IDLE;
            end
        end
    end

    assign cal_start = start_q;
    assign tmo_err   = tmo_q;
    assign busy      = (state_q == ST_RUN) || (|pend_q);
    assign all_done  = busy_q && !busy;

    a_r7_start_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cal_start));

    a_r7_start_pulse: assert property (@(posedge clk) disable iff (rst)
        (|cal_start) |=> (cal_start == '0));

    a_r7_serial: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) && $past(state_q == ST_RUN) |-> (cal_start == '0));

    a_r6_lc_gate: assert property (@(posedge clk) disable iff (rst)
        (|(cal_start & LC_MASK)) |-> $past(&(~tx_active | tx_src_frac | tx_in_reset)));

    a_r9_busy_on_start: assert property (@(posedge clk) disable iff (rst)
        (|cal_start) |-> busy);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        all_done |-> (!busy && $past(busy)));

    a_r10_tmo_from_run: assert property (@(posedge clk) disable iff (rst)
        tmo_err |-> $past(state_q == ST_RUN));

endmodule

// File: tb/xcvr_recal_seq_tb_top.sv
module xcvr_recal_seq_tb_top;
    localparam int NLC = 2, NFR = 2, NCH = 4, TMO_W = 8;
    localparam int NREQ = NLC + NFR + 2 * NCH;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic evt_valid = 0, evt_powerup = 0, refclk_bad = 0;
    logic [NLC-1:0] lc_vco_new = '0, lc_bond = '0;
    logic [NFR-1:0] frac_vco_new = '0, frac_div_only = '0, frac_bond = '0, frac_cascade = '0;
    logic [NCH-1:0] ch_cdr_txclk = '0, ch_rate_new = '0;
    logic [NCH-1:0] tx_active = '0, tx_src_frac = '0, tx_in_reset = '0;
    logic [NREQ-1:0] cal_done = '0;
    logic [TMO_W-1:0] tmo_limit = 8'd40;
    logic [NREQ-1:0] cal_start;
    logic busy, all_done, tmo_err;

    always #4 clk = ~clk;

    xcvr_recal_seq #(.NLC(NLC), .NFR(NFR), .NCH(NCH), .TMO_W(TMO_W)) dut_i (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_powerup(evt_powerup),
        .refclk_bad(refclk_bad), .lc_vco_new(lc_vco_new), .frac_vco_new(frac_vco_new),
        .frac_div_only(frac_div_only), .lc_bond(lc_bond), .frac_bond(frac_bond),
        .frac_cascade(frac_cascade), .ch_cdr_txclk(ch_cdr_txclk), .ch_rate_new(ch_rate_new),
        .tx_active(tx_active), .tx_src_frac(tx_src_frac), .tx_in_reset(tx_in_reset),
        .cal_done(cal_done), .tmo_limit(tmo_limit), .cal_start(cal_start),
        .busy(busy), .all_done(all_done), .tmo_err(tmo_err)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;

    // bench model
    bit m_run = 0, m_busy_prev = 0;
    logic [NREQ-1:0] m_pend = '0, m_cur = '0;
    int m_cnt = 0;
    // engine model
    bit eng_en = 1;
    int eng_cnt = 0;
    logic [NREQ-1:0] eng_cur = '0;
    // start log
    int slog [0:255];
    int slog_n = 0;
    int last_start_cyc = 0, last_tmo_cyc = 0;

    function automatic logic [NREQ-1:0] req_of();
        logic [NREQ-1:0] m = '0;
        if (!evt_valid) return m;
        if (evt_powerup) begin
            for (int i = 0; i < NLC; i++) m[i] = lc_bond[i] | refclk_bad;
            for (int j = 0; j < NFR; j++)
                m[NLC+j] = frac_bond[j] | frac_cascade[j] | refclk_bad;
            for (int k = 0; k < NCH; k++) begin
                m[NLC+NFR+k] = refclk_bad;
                m[NLC+NFR+NCH+k] = refclk_bad;
            end
        end else begin
            for (int i = 0; i < NLC; i++) m[i] = lc_vco_new[i];
            for (int j = 0; j < NFR; j++) m[NLC+j] = frac_vco_new[j] & ~frac_div_only[j];
            for (int k = 0; k < NCH; k++) begin
                m[NLC+NFR+k] = ch_cdr_txclk[k] | ch_rate_new[k];
                m[NLC+NFR+NCH+k] = ch_cdr_txclk[k] | ch_rate_new[k];
            end
        end
        return m;
    endfunction

    function automatic logic [NREQ-1:0] lowest(input logic [NREQ-1:0] v);
        for (int i = 0; i < NREQ; i++) if (v[i]) return NREQ'(1) << i;
        return '0;
    endfunction

    function automatic bit lc_allowed();
        for (int k = 0; k < NCH; k++)
            if (tx_active[k] && !tx_src_frac[k] && !tx_in_reset[k]) return 0;
        return 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // one clock: model the edge from inputs held before it, compare, then update stimulus
    task automatic step();
        logic [NREQ-1:0] e_start, elig;
        bit e_tmo, e_busy, e_done;
        @(negedge clk);
        cyc++;
        e_start = '0;
        e_tmo = 0;
        if (!m_run) begin
            elig = m_pend & (lc_allowed() ? '1 : ~NREQ'((1 << NLC) - 1));
            e_start = lowest(elig);
            if (e_start != '0) begin
                m_run = 1; m_cur = e_start; m_cnt = 0;
            end
        end else if ((cal_done & m_cur) != '0) begin
            m_run = 0; m_cur = '0;
        end else begin
            m_cnt++;
            if (m_cnt == int'(tmo_limit)) begin
                m_run = 0; m_cur = '0; e_tmo = 1;
            end
        end
        m_pend = (m_pend & ~e_start) | req_of();
        e_busy = m_run || (m_pend != '0);
        e_done = m_busy_prev && !e_busy;
        m_busy_prev = e_busy;

        chk(cal_start == e_start, "R8/R7 start", int'(cal_start), int'(e_start));
        chk(busy == e_busy, "R9 busy", int'(busy), int'(e_busy));
        chk(all_done == e_done, "R9 all_done", int'(all_done), int'(e_done));
        chk(tmo_err == e_tmo, "R10 tmo_err", int'(tmo_err), int'(e_tmo));

        if (cal_start != '0) begin
            for (int i = 0; i < NREQ; i++)
                if (cal_start[i] && slog_n < 256) begin slog[slog_n] = i; slog_n++; end
            last_start_cyc = cyc;
        end
        if (tmo_err) last_tmo_cyc = cyc;

        evt_valid = 0;
        cal_done = '0;
        if (eng_cnt > 0) begin
            eng_cnt--;
            if (eng_cnt == 0) cal_done = eng_cur;
        end
        if (eng_en && e_start != '0) begin
            eng_cur = e_start;
            eng_cnt = 1 + int'($urandom_range(4));
        end
    endtask

    task automatic clear_flags();
        evt_powerup = 0; refclk_bad = 0;
        lc_vco_new = '0; frac_vco_new = '0; frac_div_only = '0;
        lc_bond = '0; frac_bond = '0; frac_cascade = '0;
        ch_cdr_txclk = '0; ch_rate_new = '0;
    endtask

    task automatic drain();
        int n = 0;
        while ((busy || eng_cnt > 0) && n < 2000) begin step(); n++; end
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(cal_start == '0, "R1 start in reset", int'(cal_start), 0);
        chk(!busy && !all_done && !tmo_err, "R1 flags in reset",
            int'({busy, all_done, tmo_err}), 0);
        rst = 0;
        step();
        chk(cal_start == '0 && !busy, "R1 after reset", int'({busy, cal_start}), 0);

        // R3: divider-only change gives no request
        clear_flags(); frac_vco_new = 2'b11; frac_div_only = 2'b11; evt_valid = 1;
        step(); step();
        chk(!busy, "R3 div-only suppressed", int'(busy), 0);
        // R3: VCO change on frac 1 -> bit 3
        clear_flags(); frac_vco_new = 2'b10; evt_valid = 1; slog_n = 0;
        step(); drain();
        chk(slog_n == 1 && slog[0] == 3, "R3 frac start", slog[0], 3);

        // R6 + R2: LC 1 held while a channel transmits on an LC clock
        clear_flags(); tx_active = 4'b0100; tx_src_frac = '0; tx_in_reset = '0;
        lc_vco_new = 2'b10; evt_valid = 1; slog_n = 0;
        step();
        repeat (6) step();
        chk(slog_n == 0 && busy, "R6 lc held", slog_n, 0);
        tx_in_reset = 4'b0100;
        step(); step();
        chk(slog_n == 1 && slog[0] == 1, "R2 lc start after gate", slog[0], 1);
        drain();
        tx_active = '0; tx_in_reset = '0;

        // R4: clock-recovery PLL as TX clock on ch2 and rate change on ch0
        clear_flags(); ch_cdr_txclk = 4'b0100; ch_rate_new = 4'b0001; evt_valid = 1; slog_n = 0;
        step(); drain();
        chk(slog_n == 4, "R4 count", slog_n, 4);
        chk(slog[0] == 4 && slog[1] == 6 && slog[2] == 8 && slog[3] == 10,
            "R4 rx before tx", slog[1], 6);

        // R5: power-up with cascade on frac0 and bond on lc1
        clear_flags(); evt_powerup = 1; frac_cascade = 2'b01; lc_bond = 2'b10;
        evt_valid = 1; slog_n = 0;
        step(); drain();
        chk(slog_n == 2 && slog[0] == 1 && slog[1] == 2, "R5 bond/cascade", slog[1], 2);

        // R5 + R8: bad reference clock requests everything in index order
        clear_flags(); evt_powerup = 1; refclk_bad = 1; evt_valid = 1; slog_n = 0;
        step(); drain();
        chk(slog_n == NREQ, "R5 all requested", slog_n, NREQ);
        for (int i = 0; i < NREQ; i++)
            chk(slog[i] == i, "R8 order", slog[i], i);

        // R10: timeout when no done arrives
        eng_en = 0; tmo_limit = 8'd4;
        clear_flags(); lc_vco_new = 2'b01; evt_valid = 1;
        step(); step();
        repeat (6) step();
        chk(last_tmo_cyc - last_start_cyc == 4, "R10 timeout distance",
            last_tmo_cyc - last_start_cyc, 4);
        eng_en = 1; tmo_limit = 8'd40;
        drain();

        // random phase, including stray done bits (R7)
        for (int c = 0; c < 4000; c++) begin
            if (c % 16 == 0) begin
                tx_active = NCH'($urandom); tx_in_reset = NCH'($urandom);
                tx_src_frac = ($urandom_range(1) == 0) ? '1 : NCH'($urandom);
            end
            if ($urandom_range(7) == 0) begin
                clear_flags();
                evt_powerup = ($urandom_range(5) == 0);
                refclk_bad = ($urandom_range(3) == 0);
                lc_vco_new = NLC'($urandom); frac_vco_new = NFR'($urandom);
                frac_div_only = NFR'($urandom); lc_bond = NLC'($urandom);
                frac_bond = NFR'($urandom); frac_cascade = NFR'($urandom);
                ch_cdr_txclk = NCH'($urandom) & NCH'($urandom);
                ch_rate_new = NCH'($urandom) & NCH'($urandom);
                evt_valid = 1;
            end
            if ($urandom_range(9) == 0)
                cal_done = cal_done | ((NREQ'(1) << $urandom_range(NREQ - 1)) & ~m_cur);
            step();
        end
        tx_src_frac = '1;
        drain();
        chk(!busy, "R9 idle at end", int'(busy), 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule